// File: doc/BRIEF.md
# Secure/Non-secure Reset and Priority-Grouping Control Register

This block is one 32-bit memory-mapped control word inside a processor's system-control space. Each access arrives with a write enable, a read enable and a flag saying whether the caller runs in the secure or the non-secure state. A write lands only when its upper half carries the correct unlock key. Otherwise the whole write is thrown away.

The word holds several fields. A self-clearing system reset request leaves the block as a single-cycle pulse. A secure-only lock can take the reset request away from non-secure software. The 3-bit priority-grouping value is kept as two copies, one per security state. There is also a flag that hands fault and NMI handling to the non-secure side, a secure priority-boost enable, and a fixed endianness indication. Each field shows a view of itself that depends on the caller's state: it may be fully usable, read-only, or read-as-zero with writes ignored.

Read data is registered. It is valid in the cycle after the read enable and is zero in every other cycle. The configuration fields are also driven out as direct outputs so that neighbouring logic can use them.

Top module: `sec_rst_ctl`

## Requirements
- R1: After reset, the lock, fault-to-non-secure, boost and both priority-grouping copies are 0, and `reset_req` is low.
- R2: A write lands only if `wr_data[31:16]` equals 0x05FA. Any other key value leaves every field unchanged and raises no reset request.
- R3: Reads return 0xFA05 in bits 31:16. Bits 2:0, 7:4 and 12:11 always read 0.
- R4: An accepted write with bit 2 set, and permitted by R6, drives `reset_req` high for exactly the one cycle after the write.
- R5: Bit 3 is the reset-request lock. A secure write sets or clears it. A non-secure read sees 0, and a non-secure write leaves it unchanged.
- R6: While the lock is 1, a non-secure write of 1 to bit 2 raises no request. While the lock is 0, a non-secure write of 1 to bit 2 does raise a request. A secure write of 1 to bit 2 always raises a request.
- R7: Bits 10:8 are the priority grouping. A secure access reads and writes only the secure copy, and a non-secure access reads and writes only the non-secure copy.
- R8: Bit 13 is the fault-to-non-secure flag. A secure write updates it. Both states read its true value. A non-secure write leaves it unchanged.
- R9: Bit 14 is the secure boost enable. A secure write updates it. A non-secure read sees 0, and a non-secure write leaves it unchanged.
- R10: Bit 15 always reads the `BIG_ENDIAN` parameter (0 by default). Writes to it have no effect.
- R11: `rd_data` shows the word selected by the read in the cycle after `rd_en`. It shows the state as it was before any write in the same cycle. In all other cycles it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_data | input | 32 | Write word, key in bits 31:16 |
| rd_en | input | 1 | Read strobe for this cycle |
| acc_secure | input | 1 | 1 = access comes from the secure state |
| rd_data | output | 32 | Registered read word |
| reset_req | output | 1 | One-cycle system reset request |
| prio_group_s | output | 3 | Secure priority-grouping copy |
| prio_group_ns | output | 3 | Non-secure priority-grouping copy |
| fault_ns | output | 1 | Fault/NMI handling given to non-secure state |
| sec_boost | output | 1 | Secure priority boost enable |
| reset_lock | output | 1 | Reset request restricted to secure state |

## Verification
The assertions assume that `acc_secure` is valid whenever `wr_en` or `rd_en` is high. They also assume that both strobes stay low while reset is asserted, because several properties look one cycle back at the strobe. The stimulus drives every input on the falling edge and holds all strobes at 0 through reset. About one write in four carries a random wrong key. Both states and all data patterns are drawn at random, so permitted, locked and discarded writes all occur.

// File: rtl/srcr_pkg.sv
package srcr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned KEY_W    = 16;
  localparam int unsigned PRIO_W   = 3;
  localparam int unsigned NBANK    = 2;
  localparam int unsigned B_REQ    = 2;
  localparam int unsigned B_LOCK   = 3;
  localparam int unsigned B_PRIO   = 8;
  localparam int unsigned B_FNS    = 13;
  localparam int unsigned B_BOOST  = 14;
  localparam int unsigned B_END    = 15;
  localparam int unsigned B_KEY    = WORD_W - KEY_W;
  localparam logic [KEY_W-1:0] WR_KEY = 16'h05FA;
  localparam logic [KEY_W-1:0] RD_KEY = 16'hFA05;

  typedef enum logic {SIDE_NS = 1'b0, SIDE_S = 1'b1} side_e;

  typedef struct packed {
    logic lock;
    logic fault_ns;
    logic boost;
  } cfg_t;

  function automatic logic key_match(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:B_KEY] == WR_KEY;
  endfunction

  function automatic logic [WORD_W-1:0] compose(
      input logic              sec,
      input cfg_t              cfg,
      input logic [PRIO_W-1:0] prio,
      input logic              endian);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1:B_KEY]       = RD_KEY;
    w[B_END]                = endian;
    w[B_BOOST]              = sec & cfg.boost;
    w[B_FNS]                = cfg.fault_ns;
    w[B_PRIO+PRIO_W-1:B_PRIO] = prio;
    w[B_LOCK]               = sec & cfg.lock;
    return w;
  endfunction
endpackage

// File: rtl/srcr_prio_bank.sv
module srcr_prio_bank
  import srcr_pkg::*;
#(
  parameter int unsigned W  = PRIO_W,
  parameter int unsigned NB = NBANK
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         sel_secure,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] bank_s,
  output logic [W-1:0] bank_ns,
  output logic [W-1:0] rd_sel
);
  localparam int unsigned SEL_W = (NB > 1) ? $clog2(NB) : 1;
  logic [W-1:0] copy_q [NB];
  logic [SEL_W-1:0] idx;

  assign idx = SEL_W'(sel_secure);

  for (genvar g = 0; g < NB; g++) begin : g_copy
    logic hit;
    assign hit = we && (idx == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   copy_q[g] <= '0;
      else if (hit) copy_q[g] <= wdata;
    end
  end

  assign bank_ns = copy_q[SIDE_NS];
  assign bank_s  = copy_q[SIDE_S];
  assign rd_sel  = copy_q[idx];

  assert_bank_ns_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel_secure) |=> $stable(bank_ns));
  assert_bank_s_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel_secure) |=> $stable(bank_s));
endmodule

// File: rtl/srcr_cfg_fields.sv
module srcr_cfg_fields
  import srcr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic secure,
  input  cfg_t wcfg,
  output cfg_t cfg
);
  logic sec_wr;
  assign sec_wr = accept && secure;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (sec_wr) cfg <= wcfg;
  end

  assert_lock_ns_wi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !secure) |=> $stable(cfg.lock));
  assert_fns_ns_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !secure) |=> $stable(cfg.fault_ns));
  assert_boost_ns_wi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !secure) |=> $stable(cfg.boost));
endmodule

// File: rtl/srcr_req_pulse.sv
module srcr_req_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic secure,
  input  logic req_bit,
  input  logic lock,
  output logic reset_req
);
  logic permitted;
  logic req_take;

  assign permitted = secure || !lock;
  assign req_take  = accept && req_bit && permitted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= req_take;
  end

  assert_req_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(accept && req_bit));
  assert_locked_ns_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !secure && lock) |=> !reset_req);
  assert_secure_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && secure && req_bit) |=> reset_req);
endmodule

// File: rtl/sec_rst_ctl.sv
module sec_rst_ctl
  import srcr_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              acc_secure,
  output logic [WORD_W-1:0] rd_data,
  output logic              reset_req,
  output logic [PRIO_W-1:0] prio_group_s,
  output logic [PRIO_W-1:0] prio_group_ns,
  output logic              fault_ns,
  output logic              sec_boost,
  output logic              reset_lock
);
  logic              accept;
  cfg_t              wcfg;
  cfg_t              cfg;
  logic [PRIO_W-1:0] prio_view;
  logic [WORD_W-1:0] rd_word;
  logic              unused_wbits;

  assign accept        = wr_en && key_match(wr_data);
  assign wcfg.lock     = wr_data[B_LOCK];
  assign wcfg.fault_ns = wr_data[B_FNS];
  assign wcfg.boost    = wr_data[B_BOOST];
  assign unused_wbits  = ^{wr_data[1:0], wr_data[7:4], wr_data[12:11], wr_data[B_END]};

  srcr_prio_bank #(.W(PRIO_W), .NB(NBANK)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(accept), .sel_secure(acc_secure),
    .wdata(wr_data[B_PRIO+PRIO_W-1:B_PRIO]),
    .bank_s(prio_group_s), .bank_ns(prio_group_ns), .rd_sel(prio_view)
  );

  srcr_cfg_fields u_cfg (
    .clk(clk), .rst_n(rst_n), .accept(accept), .secure(acc_secure),
    .wcfg(wcfg), .cfg(cfg)
  );

  srcr_req_pulse u_req (
    .clk(clk), .rst_n(rst_n), .accept(accept), .secure(acc_secure),
    .req_bit(wr_data[B_REQ]), .lock(cfg.lock), .reset_req(reset_req)
  );

  assign rd_word = compose(acc_secure, cfg, prio_view, BIG_ENDIAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
    else            rd_data <= '0;
  end

  assign fault_ns   = cfg.fault_ns;
  assign sec_boost  = cfg.boost;
  assign reset_lock = cfg.lock;

  assert_rd_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[WORD_W-1:B_KEY] == RD_KEY && rd_data[2:0] == 3'b000));
  assert_rd_endian_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_data[B_END] == BIG_ENDIAN);
  assert_rd_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
  assert_bad_key_discard_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[WORD_W-1:B_KEY] != WR_KEY) |=>
      ($stable(prio_group_s) && $stable(prio_group_ns) && $stable(reset_lock)
       && $stable(fault_ns) && $stable(sec_boost) && !reset_req));
endmodule

// File: tb/sec_rst_ctl_test.sv
module sec_rst_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        acc_secure = 1'b0;
  logic [31:0] rd_data;
  logic        reset_req;
  logic [2:0]  prio_group_s, prio_group_ns;
  logic        fault_ns, sec_boost, reset_lock;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic       m_lock, m_fns, m_boost;
  logic [2:0] m_ps, m_pns;

  always #4 clk = ~clk;

  sec_rst_ctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .acc_secure(acc_secure), .rd_data(rd_data), .reset_req(reset_req),
    .prio_group_s(prio_group_s), .prio_group_ns(prio_group_ns),
    .fault_ns(fault_ns), .sec_boost(sec_boost), .reset_lock(reset_lock)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [15:0] key, input logic [2:0] p,
      input logic fns, input logic bst, input logic lk, input logic rq);
    return {key, 1'b0, bst, fns, 2'b00, p, 4'b0000, lk, rq, 2'b00};
  endfunction

  function automatic logic [31:0] exp_read(input logic sec);
    logic [31:0] v;
    v = 32'hFA05_0000;
    if (sec) v = v | (32'(m_boost) << 14) | (32'(m_lock) << 3) | (32'(m_ps) << 8);
    else     v = v | (32'(m_pns) << 8);
    v = v | (32'(m_fns) << 13);
    return v;
  endfunction

  task automatic chk_state(input string req);
    chk({req, " prio_s"},  32'(prio_group_s),  32'(m_ps));
    chk({req, " prio_ns"}, 32'(prio_group_ns), 32'(m_pns));
    chk({req, " cfg"}, {29'd0, reset_lock, fault_ns, sec_boost}, {29'd0, m_lock, m_fns, m_boost});
  endtask

  task automatic op(input logic w, input logic r, input logic [31:0] d,
                    input logic sec, input string req);
    logic [31:0] erd;
    logic        epulse;
    erd = r ? exp_read(sec) : 32'd0;
    epulse = 1'b0;
    @(negedge clk);
    wr_en = w; rd_en = r; wr_data = d; acc_secure = sec;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (w && d[31:16] == 16'h05FA) begin
      if (sec) begin
        epulse = d[2];
        m_lock = d[3]; m_fns = d[13]; m_boost = d[14]; m_ps = d[10:8];
      end else begin
        epulse = d[2] && !m_lock;
        m_pns = d[10:8];
      end
    end
    chk({req, " R4/R6 reset_req"}, 32'(reset_req), 32'(epulse));
    chk({req, " R11 rd_data"}, rd_data, erd);
    chk_state(req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    m_lock = 0; m_fns = 0; m_boost = 0; m_ps = 0; m_pns = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk_state("R1 reset");
    chk("R1 reset_req", 32'(reset_req), 32'd0);
    op(0, 1, 32'd0, 1, "R1 R3 secure read");
    op(0, 1, 32'd0, 0, "R1 R3 nonsecure read");
    // R2: wrong key discards everything
    op(1, 0, mk(16'h05FB, 3'd5, 1, 1, 1, 1), 1, "R2 bad key");
    op(1, 0, mk(16'hFA05, 3'd7, 1, 1, 1, 1), 0, "R2 read key on write");
    // R7 R8 R9: secure write
    op(1, 0, mk(16'h05FA, 3'd5, 1, 1, 0, 0), 1, "R7 R8 R9 secure write");
    op(0, 1, 32'd0, 0, "R8 R9 R5 nonsecure view");
    op(0, 1, 32'd0, 1, "R9 R7 secure view");
    // R5 R7 R8 R9: non-secure write touches only its copy
    op(1, 0, mk(16'h05FA, 3'd3, 0, 0, 1, 0), 0, "R5 R7 R8 R9 nonsecure write");
    op(0, 1, 32'd0, 0, "R7 nonsecure copy");
    // R6 unlocked non-secure request, R4 one-cycle pulse
    op(1, 0, mk(16'h05FA, 3'd3, 0, 0, 0, 1), 0, "R6 R4 nonsecure request unlocked");
    op(0, 1, 32'd0, 0, "R4 R3 pulse ended, bit2 reads 0");
    // R6 lock then non-secure blocked, secure allowed
    op(1, 0, mk(16'h05FA, 3'd5, 1, 1, 1, 0), 1, "R5 secure sets lock");
    op(1, 0, mk(16'h05FA, 3'd2, 0, 0, 0, 1), 0, "R6 nonsecure request locked");
    op(1, 0, mk(16'h05FA, 3'd5, 1, 1, 1, 1), 1, "R6 secure request locked");
    op(1, 0, mk(16'h05FA, 3'd5, 1, 1, 1, 1), 1, "R4 back-to-back request");
    // R10: endianness bit is read-only; R11 read same cycle as write
    op(1, 1, 32'h05FA_FFFF, 1, "R10 R11 write all ones");
    op(0, 1, 32'd0, 1, "R10 R3 after all ones");
    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [31:0] d;
      logic w, r, s;
      d = $urandom;
      if ($urandom % 4 != 0) d[31:16] = 16'h05FA;
      else if (d[31:16] == 16'h05FA) d[16] = 1'b1;
      w = $urandom % 2;
      r = $urandom % 2;
      s = $urandom % 2;
      op(w, r, d, s, "R2 R5 R6 R7 R8 R9 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule